// File: doc/BRIEF.md
# Radix-4 Zero-Skipping Iteration Sequencer for Late CORDIC Rotations

This block sequences the late iterations of a rotation-mode CORDIC. Once the residual angle has become small, the arctangent of 2^-i is close enough to 2^-i that the rotation directions can be read directly from the bits of the residual. The sequencer captures that residual when the datapath reaches the first late index. It recodes the residual into radix-4 signed digits, each covering two iteration positions. It then hands the datapath one nonzero digit per clock, together with the shift to apply and the index of the digit that follows.

Zero digits need no rotation, so the sequencer never issues them. A priority search over the stored nonzero mask jumps over any run of zero digits in a single step. The recoding and the first search take place in a preparation cycle ahead of the first issue. This keeps the recoding logic out of the per-iteration path, at the cost of one clock of latency. When no nonzero digit remains, the sequencer raises a completion pulse and returns to idle.

Top module: `booth_skip_seq`

## Requirements
- R1: While reset is held and after it is released, busy, dig_valid and done are low, and digit, dig_idx, shift_amt and next_idx read zero.
- R2: z_res is a 15-bit two's complement residual in units of 2^-30. Bit 14 has weight -2^-16, and bit k (k < 14) has weight 2^-(30-k). The digit for the pair that starts at even index i (16, 18, ..., 28) is computed as b(i+1) + b(i+2) - 2*b(i), where b(n) is the bit of weight 2^-n. It is output as a 3-bit two's complement value in -2..+2.
- R3: A start seen while idle loads z_res. The following cycle is a preparation cycle with busy high and dig_valid and done low. The first digit, if any, is issued in the cycle after that.
- R4: Only nonzero digits are issued, one per cycle with no gaps, in ascending index order. dig_idx is the even start index of the digit's pair.
- R5: During an issue, next_idx holds the index of the next nonzero digit, or 30 when none remains. For example, after a digit at 16 followed by two zero digits, next_idx is 22.
- R6: shift_amt equals dig_idx for a digit of magnitude 2, and dig_idx + 1 for a digit of magnitude 1.
- R7: done is high for exactly one cycle, in the cycle after the last issue, or right after the preparation cycle when every digit is zero. busy is low in the cycle after done.
- R8: A start that arrives while busy is ignored. The sequence in progress is unchanged, and no second run follows it.
- R9: The sum of digit * 2^-(dig_idx+1) over all issued digits equals the residual plus its bit 0 in units of 2^-30, which is the residual rounded to 2^-29.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request to load the residual and begin sequencing |
| z_res | input | ZW (15) | Residual angle, two's complement, LSB weight 2^-30 |
| busy | output | 1 | High from the cycle after an accepted start through the done cycle |
| dig_valid | output | 1 | A digit is issued in this cycle |
| digit | output | 3 | Signed digit, two's complement, -2..+2 |
| dig_idx | output | IDX_W (5) | Start index of the issued digit's pair |
| shift_amt | output | IDX_W (5) | Shift the datapath applies for this digit |
| next_idx | output | IDX_W (5) | Index of the next issued digit, 30 when none remains |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions take for granted that reset has been applied before the first start and that start is a clean, known level on every clock edge. They also assume that z_res is meaningful only in the cycle where start is accepted. The stimulus drives start and z_res at falling edges only and presents each residual for exactly one accepting edge. It deliberately toggles start and changes z_res during the run and during the completion cycle, so the check that such requests are ignored stays within those assumptions.

// File: rtl/booth_skip_pkg.sv
package booth_skip_pkg;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_PREP = 2'd1,
    SQ_RUN  = 2'd2,
    SQ_DONE = 2'd3
  } seq_state_e;

  // Radix-4 signed digit from a three-bit window:
  // grp[2] = heavier bit of the pair, grp[1] = lighter bit, grp[0] = bit below the pair.
  function automatic logic [2:0] booth_group(input logic [2:0] grp);
    logic [2:0] d;
    unique case (grp)
      3'b000, 3'b111: d = 3'b000;  //  0
      3'b001, 3'b010: d = 3'b001;  // +1
      3'b011:         d = 3'b010;  // +2
      3'b100:         d = 3'b110;  // -2
      default:        d = 3'b111;  // -1
    endcase
    return d;
  endfunction

  function automatic logic digit_is_double(input logic [2:0] d);
    return (d == 3'b010) || (d == 3'b110);
  endfunction

  function automatic logic digit_in_range(input logic [2:0] d);
    return (d != 3'b011) && (d != 3'b100) && (d != 3'b101);
  endfunction

endpackage

// File: rtl/booth_recoder.sv
module booth_recoder
  import booth_skip_pkg::*;
#(
  parameter  int NDIG = 7,
  localparam int ZW   = 2 * NDIG + 1
) (
  input  logic [ZW-1:0]          z,
  output logic [NDIG-1:0][2:0]   dig,
  output logic [NDIG-1:0]        nz
);

  // Digit j covers the pair whose heavier bit sits at z[ZW-1-2j];
  // its window reaches down to z[ZW-3-2j].
  for (genvar j = 0; j < NDIG; j++) begin : g_digit
    logic [2:0] win;
    assign win    = z[ZW-1-2*j -: 3];
    assign dig[j] = booth_group(win);
    // Zero digit exactly when the window is uniform.
    assign nz[j]  = (win != 3'b000) && (win != 3'b111);
  end

endmodule

// File: rtl/lowbit_finder.sv
module lowbit_finder #(
  parameter  int N  = 7,
  localparam int PW = $clog2(N + 1)
) (
  input  logic [N-1:0]  mask,
  output logic [PW-1:0] pos,
  output logic          hit
);

  // Lowest set bit; pos = N when the mask is empty.
  always_comb begin
    pos = PW'(N);
    hit = 1'b0;
    for (int k = N - 1; k >= 0; k--) begin
      if (mask[k]) begin
        pos = PW'(k);
        hit = 1'b1;
      end
    end
  end

endmodule

// File: rtl/booth_skip_seq.sv
module booth_skip_seq
  import booth_skip_pkg::*;
#(
  parameter  int FIRST_IDX = 16,
  parameter  int LAST_IDX  = 29,
  localparam int NDIG      = (LAST_IDX - FIRST_IDX + 1) / 2,
  localparam int ZW        = 2 * NDIG + 1,
  localparam int IDX_W     = $clog2(LAST_IDX + 2)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [ZW-1:0]    z_res,
  output logic             busy,
  output logic             dig_valid,
  output logic [2:0]       digit,
  output logic [IDX_W-1:0] dig_idx,
  output logic [IDX_W-1:0] shift_amt,
  output logic [IDX_W-1:0] next_idx,
  output logic             done
);

  localparam int PW      = $clog2(NDIG + 1);
  localparam int END_IDX = LAST_IDX + 1;

  function automatic logic [IDX_W-1:0] pos_idx(input logic [PW-1:0] p);
    return IDX_W'(FIRST_IDX + 2 * int'(p));
  endfunction

  seq_state_e            st_q;
  logic [NDIG-1:0][2:0]  dig_q;
  logic [NDIG-1:0]       nz_q;
  logic [PW-1:0]         cur_q;
  logic [PW-1:0]         nxt_q;

  // Recoding of the incoming residual (registered on accept).
  logic [NDIG-1:0][2:0]  rec_dig;
  logic [NDIG-1:0]       rec_nz;

  booth_recoder #(.NDIG(NDIG)) u_rec (
    .z   (z_res),
    .dig (rec_dig),
    .nz  (rec_nz)
  );

  // Search masks: finder A gives the first digit in PREP and the
  // digit after nxt_q in RUN; finder B gives the second digit in PREP.
  logic [NDIG-1:0] above_nxt;
  logic [NDIG-1:0] mask_a;
  logic [NDIG-1:0] mask_b;
  logic [PW-1:0]   pos_a, pos_b;
  logic            hit_a, hit_b;

  always_comb begin
    for (int k = 0; k < NDIG; k++) begin
      above_nxt[k] = (k > int'(nxt_q));
    end
  end

  assign mask_a = (st_q == SQ_PREP) ? nz_q : (nz_q & above_nxt);
  assign mask_b = nz_q & (nz_q - NDIG'(1));

  lowbit_finder #(.N(NDIG)) u_find_a (.mask(mask_a), .pos(pos_a), .hit(hit_a));
  lowbit_finder #(.N(NDIG)) u_find_b (.mask(mask_b), .pos(pos_b), .hit(hit_b));

  // Named events.
  logic accept_evt;
  logic ignored_evt;
  logic issue_evt;
  logic last_issue_evt;
  logic empty_evt;

  assign accept_evt     = start && (st_q == SQ_IDLE);
  assign ignored_evt    = start && (st_q != SQ_IDLE);
  assign issue_evt      = (st_q == SQ_RUN);
  assign last_issue_evt = issue_evt && (nxt_q == PW'(NDIG));
  assign empty_evt      = (st_q == SQ_PREP) && !hit_a;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= SQ_IDLE;
      dig_q <= '0;
      nz_q  <= '0;
      cur_q <= '0;
      nxt_q <= '0;
    end else begin
      unique case (st_q)
        SQ_IDLE: begin
          if (accept_evt) begin
            dig_q <= rec_dig;
            nz_q  <= rec_nz;
            st_q  <= SQ_PREP;
          end
        end
        SQ_PREP: begin
          if (hit_a) begin
            cur_q <= pos_a;
            nxt_q <= hit_b ? pos_b : PW'(NDIG);
            st_q  <= SQ_RUN;
          end else begin
            st_q  <= SQ_DONE;
          end
        end
        SQ_RUN: begin
          if (last_issue_evt) begin
            st_q  <= SQ_DONE;
          end else begin
            cur_q <= nxt_q;
            nxt_q <= pos_a;
          end
        end
        default: st_q <= SQ_IDLE;
      endcase
    end
  end

  // Outputs.
  logic [2:0]       cur_dig;
  logic [IDX_W-1:0] cur_idx;

  assign cur_dig   = dig_q[cur_q];
  assign cur_idx   = pos_idx(cur_q);

  assign busy      = (st_q != SQ_IDLE);
  assign dig_valid = issue_evt;
  assign done      = (st_q == SQ_DONE);
  assign digit     = issue_evt ? cur_dig : 3'b000;
  assign dig_idx   = issue_evt ? cur_idx : '0;
  assign shift_amt = !issue_evt ? '0 :
                     (digit_is_double(cur_dig) ? cur_idx : cur_idx + IDX_W'(1));
  assign next_idx  = !issue_evt ? '0 :
                     (last_issue_evt ? IDX_W'(END_IDX) : pos_idx(nxt_q));

  // Assertions.
  AST_ISSUE_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    dig_valid |-> (digit != 3'b000) && digit_in_range(digit)); // R4

  AST_IDX_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    dig_valid |-> (int'(dig_idx) >= FIRST_IDX) && (int'(dig_idx) < LAST_IDX)); // R4

  AST_ASCENDING: assert property (@(posedge clk) disable iff (!rst_n)
    dig_valid |-> next_idx > dig_idx); // R4

  AST_CHAIN_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (dig_valid && (int'(next_idx) != END_IDX)) |=> dig_valid && (dig_idx == $past(next_idx))); // R5

  AST_END_TO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (dig_valid && (int'(next_idx) == END_IDX)) |=> done && !dig_valid); // R7

  AST_EMPTY_TO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    empty_evt |=> done); // R7

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy); // R7

  AST_PREP_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    accept_evt |=> busy && !dig_valid && !done); // R3

  AST_SHIFT_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    dig_valid |-> (shift_amt == dig_idx) || (shift_amt == dig_idx + IDX_W'(1))); // R6

  AST_IGNORE_START: assert property (@(posedge clk) disable iff (!rst_n)
    ignored_evt |=> $stable(nz_q) && $stable(dig_q)); // R8

endmodule

// File: tb/booth_skip_seq_bench.sv
`timescale 1ns/1ps
module booth_skip_seq_bench;

  localparam int FIRST = 16;
  localparam int NDIG  = 7;
  localparam int ZW    = 15;
  localparam int IW    = 5;
  localparam int ENDI  = 30;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [ZW-1:0] z = '0;
  logic          busy, dig_valid, done;
  logic [2:0]    digit;
  logic [IW-1:0] dig_idx, shift_amt, next_idx;

  always #10 clk = ~clk;

  booth_skip_seq u_booth_skip_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .z_res(z),
    .busy(busy), .dig_valid(dig_valid), .digit(digit),
    .dig_idx(dig_idx), .shift_amt(shift_amt), .next_idx(next_idx), .done(done)
  );

  typedef struct {
    int idx;
    int dig;
    int sh;
    int nx;
    bit fin;
  } exp_t;

  exp_t          sb[$];
  int            n_tests = 0;
  int            n_fail  = 0;
  longint        recon   = 0;
  logic [ZW-1:0] cur_z   = '0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  // Bit of weight 2^-n in the residual.
  function automatic int wbit(input logic [ZW-1:0] v, input int n);
    return int'(v[30 - n]);
  endfunction

  // Monitor: pops the scoreboard as results appear.
  always @(negedge clk) begin
    if (rst_n) begin
      if (dig_valid) begin
        if (sb.size() == 0 || sb[0].fin) begin
          check(1'b0, "R4", "unexpected issue idx", longint'(dig_idx), -1);
        end else begin
          exp_t e;
          int   ad;
          e  = sb.pop_front();
          ad = int'($signed(digit));
          check(int'(dig_idx) == e.idx, "R4", "dig_idx", longint'(dig_idx), e.idx);
          check(ad == e.dig, "R2", "digit", ad, e.dig);
          check(int'(shift_amt) == e.sh, "R6", "shift_amt", longint'(shift_amt), e.sh);
          check(int'(next_idx) == e.nx, "R5", "next_idx", longint'(next_idx), e.nx);
          recon += longint'(ad) * (longint'(1) <<< (29 - int'(dig_idx)));
        end
      end
      if (done) begin
        longint want;
        if (sb.size() == 0 || !sb[0].fin) begin
          check(1'b0, "R7", "done before last digit, pending", sb.size(), 0);
        end else begin
          void'(sb.pop_front());
        end
        want = longint'($signed(cur_z)) + longint'(cur_z[0]);
        check(recon == want, "R9", "reconstructed residual", recon, want);
      end
    end
  end

  // Driver: ign selects a stray start (0 none, 1 first issue cycle, 2 done cycle).
  task automatic run_vec(input logic [ZW-1:0] zv, input int ign);
    int   k = 0;
    int   ign_c;
    int   digs[NDIG];
    exp_t e;
    for (int j = 0; j < NDIG; j++) begin
      int i = FIRST + 2 * j;
      digs[j] = wbit(zv, i + 1) + wbit(zv, i + 2) - 2 * wbit(zv, i);
    end
    for (int j = 0; j < NDIG; j++) begin
      if (digs[j] != 0) begin
        int nx = ENDI;
        for (int m = NDIG - 1; m > j; m--) if (digs[m] != 0) nx = FIRST + 2 * m;
        e.idx = FIRST + 2 * j;
        e.dig = digs[j];
        e.sh  = (digs[j] == 2 || digs[j] == -2) ? e.idx : e.idx + 1;
        e.nx  = nx;
        e.fin = 1'b0;
        sb.push_back(e);
        k++;
      end
    end
    e.idx = 0; e.dig = 0; e.sh = 0; e.nx = 0; e.fin = 1'b1;
    sb.push_back(e);
    ign_c = (ign == 1) ? 0 : ((ign == 2) ? k : -1);

    @(negedge clk);
    cur_z = zv;
    recon = 0;
    z     = zv;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy && !dig_valid && !done, "R3", "prep cycle busy/valid/done",
          {busy, dig_valid, done}, 3'b100);
    for (int c = 0; c <= k; c++) begin
      @(negedge clk);
      start = (c == ign_c);
      z     = (c == ign_c) ? ~zv : zv;
      if (c == k) check(done == 1'b1, "R7", "done after last issue", done, 1);
      else        check(dig_valid == 1'b1, "R4", "issue without gap", dig_valid, 1);
    end
    @(negedge clk);
    start = 1'b0;
    check(!busy && !done, "R7", "idle after done (busy,done)", {busy, done}, 0);
    if (ign != 0) check(!busy, "R8", "no second run after stray start", busy, 0);
    check(sb.size() == 0, "R4", "scoreboard drained", sb.size(), 0);
    @(negedge clk);
    check(!busy, "R8", "still idle", busy, 0);
  endtask

  initial begin
    logic [ZW-1:0] fixed[10];
    fixed[0] = 15'h0000; fixed[1] = 15'h7FFF; fixed[2] = 15'h4000;
    fixed[3] = 15'h2080; fixed[4] = 15'h0001; fixed[5] = 15'h2AAA;
    fixed[6] = 15'h5555; fixed[7] = 15'h1FFF; fixed[8] = 15'h3C3C;
    fixed[9] = 15'h6001;

    repeat (3) @(negedge clk);
    check(!busy && !dig_valid && !done, "R1", "flags in reset", {busy, dig_valid, done}, 0);
    check(digit == 0 && dig_idx == 0 && shift_amt == 0 && next_idx == 0, "R1",
          "data outputs in reset", {digit, dig_idx, shift_amt, next_idx}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !dig_valid && !done, "R1", "flags after reset", {busy, dig_valid, done}, 0);

    // R5 example: digit at 16, zeros at 18 and 20, next at 22.
    run_vec(15'h2080, 0);
    for (int v = 0; v < 10; v++) run_vec(fixed[v], v % 3);
    for (int v = 0; v < 24; v++) run_vec(ZW'($urandom), v % 3);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL R7 watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule